// File: doc/BRIEF.md
# Three-Register ALU Execute Stage

This block is the register-to-register execute stage of a 32-bit load/store processor. Each cycle it accepts one 32-bit instruction word together with a valid strobe. It splits the word into an opcode and three register selectors and reads two source operands from its own 32-entry by 32-bit register file. It then computes an arithmetic, shift or logic result and writes it back at the next rising clock edge. A move-immediate instruction places a sign-extended 16-bit constant into a register.

Results and control appear on the writeback outputs in the same cycle as the instruction. The register file commits the write at the clock edge that ends that cycle. Two fault conditions are reported on a one-hot trap output: a zero divisor, and an opcode beyond the defined set. Either fault suppresses the writeback. Opcodes that belong to other pipeline units, such as memory access, compare, branch, jump and system call, pass through. They cause no write and no trap.

The asynchronous active-low reset clears the register file. Its release is synchronised to the clock inside the block, so instructions take effect from the third rising edge after `rst_n` goes high.

Top module: `rr_exec_stage`

## Requirements
- R1: Field positions in the instruction word: opcode is bits 31:26, destination select `a` is bits 25:21, source select `b` is bits 20:16, source select `c` is bits 15:11 and the immediate is bits 15:0. Register-to-register operations write reg[a] with reg[b] op reg[c], and `wb_addr` shows `a`.
- R2: Opcode 0 adds, 1 subtracts and 2 multiplies. All three are unsigned, modulo 2^32, and multiply keeps the low 32 bits of the product.
- R3: Opcode 3 gives the unsigned quotient reg[b]/reg[c] and opcode 4 gives the unsigned remainder, when reg[c] is not zero.
- R4: Opcode 5 shifts reg[b] left and opcode 6 shifts it right logically. The shift amount is the low 5 bits of reg[c] only.
- R5: Opcode 7 gives AND, 8 gives OR, 9 gives XOR and 10 gives NOR, where NOR is ~(reg[b] | reg[c]).
- R6: Register 0 always reads as zero, even after an instruction has written to it.
- R7: Opcode 11 (move-immediate) writes the sign-extended bits 15:0 into reg[b], and `wb_addr` shows `b`.
- R8: Opcode 3 or 4 with reg[c] equal to zero sets `trap` to 2'b01, holds `wb_en` low and leaves every register unchanged.
- R9: Any opcode from 28 to 63 sets `trap` to 2'b10, holds `wb_en` low and leaves every register unchanged.
- R10: Opcodes 12 to 27 produce no write and no trap.
- R11: `trap` is one-hot or zero. Bit 0 means divide-by-zero and bit 1 means illegal opcode. With `instr_valid` low, `wb_en` and `trap` are both zero.
- R12: After reset every register reads zero. A write made in one cycle is seen by the source reads of the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| wb_en | output | 1 | Writeback happens at the coming edge |
| wb_addr | output | 5 | Register written back |
| wb_data | output | 32 | Value written back |
| trap | output | 2 | One-hot trap: bit 0 divide-by-zero, bit 1 illegal opcode |

## Verification
The bench sweeps every arithmetic, shift and logic opcode over all pairs of eight source registers. The sources hold zero, one, all-ones, the sign bit alone, a mixed pattern, 31, 32 and 7. This catches a shift that uses more than five bits, because a shift by 32 would then clear the value instead of leaving it unchanged. It also catches a NOR built from AND, or a signed division. Zero divisors come from the same sweep. A design that did not trap would show a quotient, and one that trapped but still wrote would be caught when the destination is read back. Every undefined and every foreign opcode is issued in turn. Writes to register 0, negative immediates and the reset contents are read back through an OR probe, which exposes a stored zero register, zero-extension or incomplete reset.

// File: rtl/rr_exec_pkg.sv
package rr_exec_pkg;
  // Instruction field geometry
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int SEL_W   = 5;
  localparam int IMM_W   = 16;
  localparam int OPC_LSB = 26;
  localparam int SA_LSB  = 21;
  localparam int SB_LSB  = 16;
  localparam int SC_LSB  = 11;

  // Opcode numbering
  localparam logic [OPC_W-1:0] OP_ADD = 6'd0;
  localparam logic [OPC_W-1:0] OP_SUB = 6'd1;
  localparam logic [OPC_W-1:0] OP_MUL = 6'd2;
  localparam logic [OPC_W-1:0] OP_DIV = 6'd3;
  localparam logic [OPC_W-1:0] OP_MOD = 6'd4;
  localparam logic [OPC_W-1:0] OP_SHL = 6'd5;
  localparam logic [OPC_W-1:0] OP_SHR = 6'd6;
  localparam logic [OPC_W-1:0] OP_AND = 6'd7;
  localparam logic [OPC_W-1:0] OP_OR  = 6'd8;
  localparam logic [OPC_W-1:0] OP_XOR = 6'd9;
  localparam logic [OPC_W-1:0] OP_NOR = 6'd10;
  localparam logic [OPC_W-1:0] OP_MOV = 6'd11;
  localparam logic [OPC_W-1:0] OP_LAST = 6'd27;

  // Trap vector bit positions
  localparam int TRAP_W    = 2;
  localparam int TRAP_DIVZ = 0;
  localparam int TRAP_ILL  = 1;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_c;
    logic [IMM_W-1:0] imm;
  } fields_t;
endpackage

// File: rtl/rr_reset_sync.sv
module rr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/rr_field_decode.sv
module rr_field_decode
  import rr_exec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output fields_t            fld,
  output logic               cls_arith,
  output logic               cls_mov,
  output logic               cls_foreign,
  output logic               cls_illegal
);
  always_comb begin
    fld.opc   = instr[OPC_LSB +: OPC_W];
    fld.sel_a = instr[SA_LSB +: SEL_W];
    fld.sel_b = instr[SB_LSB +: SEL_W];
    fld.sel_c = instr[SC_LSB +: SEL_W];
    fld.imm   = instr[IMM_W-1:0];
  end

  always_comb begin
    cls_arith   = (fld.opc <= OP_NOR);
    cls_mov     = (fld.opc == OP_MOV);
    cls_foreign = (fld.opc > OP_MOV) && (fld.opc <= OP_LAST);
    cls_illegal = (fld.opc > OP_LAST);
  end
endmodule

// File: rtl/rr_regfile.sv
module rr_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_req,
  input  logic [AW-1:0]   wr_sel,
  input  logic [XLEN-1:0] wr_data,
  input  logic [AW-1:0]   rd_sel_b,
  input  logic [AW-1:0]   rd_sel_c,
  output logic [XLEN-1:0] rd_data_b,
  output logic [XLEN-1:0] rd_data_c
);
  logic [NREG-1:0][XLEN-1:0] view;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_ent
    if (gi == 0) begin : g_zero
      assign view[gi] = '0;
    end else begin : g_store
      logic            ce;
      logic [XLEN-1:0] d;
      logic [XLEN-1:0] q;

      always_comb begin
        ce = wr_req && (wr_sel == AW'(gi));
        d  = ce ? wr_data : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (ce) begin
          q <= d;
        end
      end

      assign view[gi] = q;
    end
  end

  assign rd_data_b = view[rd_sel_b];
  assign rd_data_c = view[rd_sel_c];
endmodule

// File: rtl/rr_alu.sv
module rr_alu
  import rr_exec_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  src_b,
  input  logic [XLEN-1:0]  src_c,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  result,
  output logic             div_zero
);
  logic             divisor_zero;
  logic [XLEN-1:0]  divisor;
  logic [SHW-1:0]   shamt;
  logic [XLEN-1:0]  imm_ext;

  always_comb begin
    divisor_zero = (src_c == '0);
    divisor      = divisor_zero ? XLEN'(1) : src_c;
    shamt        = src_c[SHW-1:0];
    imm_ext      = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    div_zero     = divisor_zero && ((opc == OP_DIV) || (opc == OP_MOD));
  end

  always_comb begin
    unique case (opc)
      OP_ADD:  result = src_b + src_c;
      OP_SUB:  result = src_b - src_c;
      OP_MUL:  result = src_b * src_c;
      OP_DIV:  result = src_b / divisor;
      OP_MOD:  result = src_b % divisor;
      OP_SHL:  result = src_b << shamt;
      OP_SHR:  result = src_b >> shamt;
      OP_AND:  result = src_b & src_c;
      OP_OR:   result = src_b | src_c;
      OP_XOR:  result = src_b ^ src_c;
      OP_NOR:  result = ~(src_b | src_c);
      OP_MOV:  result = imm_ext;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/rr_exec_stage.sv
module rr_exec_stage
  import rr_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic               wb_en,
  output logic [AW-1:0]      wb_addr,
  output logic [XLEN-1:0]    wb_data,
  output logic [TRAP_W-1:0]  trap
);
  logic            rst_sync_n;
  fields_t         fld;
  logic            cls_arith;
  logic            cls_mov;
  logic            cls_foreign;
  logic            cls_illegal;
  logic [XLEN-1:0] rf_rd_b;
  logic [XLEN-1:0] rf_rd_c;
  logic [XLEN-1:0] alu_res;
  logic            alu_div_zero;
  logic            active;
  logic            wr_req;

  rr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rr_field_decode u_dec (
    .instr       (instr),
    .fld         (fld),
    .cls_arith   (cls_arith),
    .cls_mov     (cls_mov),
    .cls_foreign (cls_foreign),
    .cls_illegal (cls_illegal)
  );

  rr_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_req    (wr_req),
    .wr_sel    (wb_addr),
    .wr_data   (alu_res),
    .rd_sel_b  (fld.sel_b[AW-1:0]),
    .rd_sel_c  (fld.sel_c[AW-1:0]),
    .rd_data_b (rf_rd_b),
    .rd_data_c (rf_rd_c)
  );

  rr_alu #(.XLEN(XLEN)) u_alu (
    .opc      (fld.opc),
    .src_b    (rf_rd_b),
    .src_c    (rf_rd_c),
    .imm      (fld.imm),
    .result   (alu_res),
    .div_zero (alu_div_zero)
  );

  always_comb begin
    active              = instr_valid && rst_sync_n;
    wr_req              = active && ((cls_arith && !alu_div_zero) || cls_mov);
    wb_en               = wr_req;
    wb_addr             = cls_mov ? fld.sel_b[AW-1:0] : fld.sel_a[AW-1:0];
    wb_data             = alu_res;
    trap                = '0;
    trap[TRAP_DIVZ]     = active && cls_arith && alu_div_zero;
    trap[TRAP_ILL]      = active && cls_illegal;
  end

  // Foreign opcodes are accepted here and executed by other units.
  logic unused_foreign;
  assign unused_foreign = cls_foreign;
endmodule

// File: rtl/rr_exec_checker.sv
module rr_exec_checker
  import rr_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               wb_en,
  input logic [AW-1:0]      wb_addr,
  input logic [XLEN-1:0]    wb_data,
  input logic [TRAP_W-1:0]  trap,
  input logic [XLEN-1:0]    src_c
);
  logic [OPC_W-1:0] opc;
  logic [IMM_W-1:0] imm;
  assign opc = instr[OPC_LSB +: OPC_W];
  assign imm = instr[IMM_W-1:0];

  AST_TRAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(trap)); // R11
  AST_TRAP_BLOCKS_WB: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (trap != '0) |-> !wb_en); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !instr_valid |-> (!wb_en && trap == '0)); // R11
  AST_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && (opc == OP_DIV || opc == OP_MOD) && src_c == '0) |-> trap == 2'b01); // R8
  AST_ILLEGAL_OPC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && opc > OP_LAST) |-> (trap == 2'b10 && !wb_en)); // R9
  AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && opc > OP_MOV && opc <= OP_LAST) |-> (trap == '0 && !wb_en)); // R10
  AST_ZERO_REG_ADD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && opc == OP_ADD && instr[SB_LSB +: SEL_W] == '0 && instr[SC_LSB +: SEL_W] == '0)
      |-> wb_data == '0); // R6
  AST_MOV_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (instr_valid && opc == OP_MOV) |->
      (wb_en && wb_addr == instr[SB_LSB +: AW] && wb_data == {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm})); // R7
endmodule

bind rr_exec_stage rr_exec_checker #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .instr_valid (instr_valid),
  .instr       (instr),
  .wb_en       (wb_en),
  .wb_addr     (wb_addr),
  .wb_data     (wb_data),
  .trap        (trap),
  .src_c       (rf_rd_c)
);

// File: tb/rr_exec_stage_bench.sv
module rr_exec_stage_bench;
  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic        wb_en;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;
  logic [1:0]  trap;

  int checks;
  int errors;
  logic [31:0] model [32];

  rr_exec_stage u_rr_exec_stage (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data), .trap(trap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input int op, input int a, input int b, input int c, input logic [15:0] imm);
    logic [31:0] w;
    w = {op[5:0], a[4:0], b[4:0], 16'h0};
    if (op == 11 || op >= 12) w[15:0] = imm;
    else w[15:11] = c[4:0];
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Issue one instruction, compare writeback/trap against the model, update the model.
  task automatic exec(input logic [31:0] ins, input string tag_in);
    int op, a, b, c;
    logic [31:0] vb, vc, res, imx;
    logic        e_en;
    logic [4:0]  e_addr;
    logic [1:0]  e_trap;
    logic [39:0] act, exp;
    string tag;
    op = int'(ins[31:26]); a = int'(ins[25:21]); b = int'(ins[20:16]); c = int'(ins[15:11]);
    vb = model[b]; vc = model[c];
    imx = {{16{ins[15]}}, ins[15:0]};
    e_en = 1'b0; e_addr = 5'(a); e_trap = 2'b00; res = '0;
    tag = "R1";
    case (op)
      0: begin res = vb + vc; tag = "R2"; end
      1: begin res = vb - vc; tag = "R2"; end
      2: begin res = vb * vc; tag = "R2"; end
      3: begin tag = "R3"; if (vc == 0) begin e_trap = 2'b01; tag = "R8"; end else res = vb / vc; end
      4: begin tag = "R3"; if (vc == 0) begin e_trap = 2'b01; tag = "R8"; end else res = vb % vc; end
      5: begin res = vb << (vc & 32'd31); tag = "R4"; end
      6: begin res = vb >> (vc & 32'd31); tag = "R4"; end
      7: begin res = vb & vc; tag = "R5"; end
      8: begin res = vb | vc; tag = "R5"; end
      9: begin res = vb ^ vc; tag = "R5"; end
      10: begin res = ~(vb | vc); tag = "R5"; end
      11: begin res = imx; e_addr = 5'(b); tag = "R7"; end
      default: begin
        if (op > 27) begin e_trap = 2'b10; tag = "R9"; end
        else tag = "R10";
      end
    endcase
    if (op <= 11 && e_trap == 2'b00) e_en = 1'b1;
    if (tag_in != "") tag = tag_in;
    @(negedge clk);
    instr = ins; instr_valid = 1'b1;
    #1;
    act = {wb_en, wb_en ? wb_addr : 5'd0, wb_en ? wb_data : 32'd0, trap};
    exp = {e_en, e_en ? e_addr : 5'd0, e_en ? res : 32'd0, e_trap};
    chk(act == exp, tag, act, exp);
    if (e_en && e_addr != 5'd0) model[e_addr] = res;
  endtask

  // OR r0 <- rX | r0 exposes register X on wb_data.
  task automatic probe(input int r, input string tag);
    exec(mk(8, 0, r, 0, 16'h0), tag);
  endtask

  task automatic load_reg(input int r, input logic [31:0] v);
    exec(mk(11, 0, 28, 0, v[31:16]), "R7");
    exec(mk(11, 0, 30, 0, 16'd16), "R7");
    exec(mk(5, 28, 28, 30, 16'h0), "R4");
    exec(mk(11, 0, 29, 0, v[15:0]), "R7");
    exec(mk(5, 29, 29, 30, 16'h0), "R4");
    exec(mk(6, 29, 29, 30, 16'h0), "R4");
    exec(mk(8, r, 28, 29, 16'h0), "R1");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] vals [8];
    logic [15:0] imms [6];
    checks = 0; errors = 0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'd31, 32'd32, 32'd7};
    imms = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hA5C3};
    rst_n = 1'b0; instr_valid = 1'b0; instr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R12 reset contents
    for (int r = 0; r < 32; r++) probe(r, "R12");

    // R11 idle: no writeback, no trap, for several words
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); instr_valid = 1'b0; instr = mk(k * 9, 3, 4, 5, 16'h0);
      #1;
      chk(!wb_en && trap == 2'b00, "R11", {38'd0, trap}, 40'd0);
    end

    for (int r = 1; r <= 8; r++) load_reg(r, vals[r-1]);

    // R2-R5, R8 sweep with read-back (R12)
    for (int op = 0; op <= 10; op++)
      for (int b = 1; b <= 8; b++)
        for (int c = 1; c <= 8; c++) begin
          exec(mk(op, 9 + op, b, c, 16'h0), "");
          probe(9 + op, "R12");
        end

    // R7 move-immediate sign extension into reg b
    for (int i = 0; i < 6; i++) begin
      exec(mk(11, 2, 20 + i, 0, imms[i]), "R7");
      probe(20 + i, "R7");
    end

    // R6 register 0 stays zero after writes
    exec(mk(11, 0, 0, 0, 16'h1234), "R6");
    probe(0, "R6");
    exec(mk(0, 0, 3, 3, 16'h0), "R6");
    probe(0, "R6");
    exec(mk(0, 12, 0, 0, 16'h0), "R6");

    // R8 zero divisor: register unchanged
    exec(mk(3, 5, 3, 0, 16'h0), "R8");
    probe(5, "R8");
    exec(mk(4, 6, 3, 1, 16'h0), "R8");
    probe(6, "R8");

    // R9 illegal opcodes, R10 foreign opcodes
    for (int op = 12; op < 64; op++) begin
      exec({op[5:0], 5'd7, 5'd7, 16'hFFFF}, "");
      probe(7, op > 27 ? "R9" : "R10");
    end

    // R1 every destination
    for (int a = 1; a < 32; a++) begin
      exec(mk(9, a, 4, 5, 16'h0), "R1");
      probe(a, "R1");
    end

    @(negedge clk); instr_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule